// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small processor core that completes one instruction on every clock edge outside reset. A program counter holds byte addresses, and instruction and data storage sit in two internal word arrays. A register file holds 32 registers of 32 bits. A combinational decoder turns the opcode and function code into a packed set of control strobes. A datapath holds the program counter, the register file, both memories, the adder/subtracter/comparator and the next-address selection.

The core runs a compact subset of instructions. The register-to-register group is add, subtract and signed set-less-than. Memory access is limited to word loads and stores. Control flow covers equal and not-equal branches, an absolute jump and a jump through a register. Together these are enough for loops, if/else chains and jump-table dispatch.

Software does not run on this core in the usual sense. A test environment writes words into either memory through a load port while reset is held. It then releases reset and reads the register file, one data word and the program counter through debug read ports.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high the program counter is 0 and every register reads 0; reset may be reapplied at any time with the same effect.
- R2: Register 0 always reads 0; an instruction that names it as destination leaves it at 0.
- R3: Register-format words are split MSB-first into opcode[31:26], rs[25:21], rt[20:16], rd[15:11], an ignored 5-bit field [10:6] and function[5:0]. With opcode 0, function 32 writes rs+rt to rd and function 34 writes rs−rt to rd (wrapping modulo 2^32).
- R4: Opcode 0 with function 42 writes 1 to rd when rs is less than rt as two's-complement values, else 0.
- R5: Immediate-format words carry opcode[31:26], rs[25:21], rt[20:16] and a 16-bit offset[15:0]. Opcode 35 loads the data word at byte address rs + sign-extended offset into rt.
- R6: Opcode 43 stores rt to the data word at byte address rs + sign-extended offset.
- R7: Each instruction that is not a taken branch or jump sets the program counter to its own address plus 4, one instruction per clock.
- R8: Opcode 4 branches when rs equals rt and opcode 5 branches when they differ. The target is PC+4 plus the sign-extended offset shifted left by 2; otherwise PC+4.
- R9: Opcode 2 jumps to {(PC+4)[31:28], instr[25:0], 2'b00}.
- R10: Opcode 0 with function 8 sets the program counter to the value of rs.
- R11: Any other opcode, or opcode 0 with any other function, changes no register and no memory word and only advances the program counter by 4.
- R12: When `loadEn` is high, `loadData` is written at the rising edge to word `loadAddr` of data memory if `loadToData` is 1, else of instruction memory; `dbgMemData` returns data word `dbgMemAddr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Preload write strobe |
| loadToData | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| loadAddr | input | LOAD_AW | Preload word index |
| loadData | input | 32 | Preload word |
| dbgRegAddr | input | 5 | Register index to observe |
| dbgRegData | output | 32 | Value of the observed register |
| dbgMemAddr | input | DMEM_AW | Data word index to observe |
| dbgMemData | output | 32 | Value of the observed data word |
| dbgPc | output | 32 | Current program counter |

## Verification
One preloaded program exercises the core. It loads a positive and a negative operand so that add, subtract and signed compare give results that differ from their unsigned or swapped-operand forms. Each branch kind is run both taken and not taken, with a marker instruction in the skipped slot; a marker register that stays zero tells a taken branch from a fall-through. A word stored and then loaded back, together with a load through a negative offset from a pointer fetched from a jump table, separates correct address arithmetic from plain use of the base. An unused opcode placed before a dependent add, a write aimed at register 0, early program-counter steps and a second reset in mid-run cover the remaining corners.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_JMP  = 6'd2;
  localparam logic [5:0] OP_BEQ  = 6'd4;
  localparam logic [5:0] OP_BNE  = 6'd5;
  localparam logic [5:0] OP_LDW  = 6'd35;
  localparam logic [5:0] OP_STW  = 6'd43;
  localparam logic [5:0] FN_JREG = 6'd8;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_SLT  = 6'd42;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT} aluOpE;

  typedef struct packed {
    logic  regWrite;
    logic  regDstRd;
    logic  aluSrcImm;
    aluOpE aluOp;
    logic  memToReg;
    logic  memWrite;
    logic  brEq;
    logic  brNe;
    logic  jump;
    logic  jumpReg;
  } ctrlT;
endpackage

// File: rtl/sc_control.sv
module sc_control
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrlT       ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_ADD;
    unique case (opcode)
      OP_REG: begin
        unique case (funct)
          FN_ADD:  begin ctrl.regWrite = 1'b1; ctrl.regDstRd = 1'b1; ctrl.aluOp = ALU_ADD; end
          FN_SUB:  begin ctrl.regWrite = 1'b1; ctrl.regDstRd = 1'b1; ctrl.aluOp = ALU_SUB; end
          FN_SLT:  begin ctrl.regWrite = 1'b1; ctrl.regDstRd = 1'b1; ctrl.aluOp = ALU_SLT; end
          FN_JREG: ctrl.jumpReg = 1'b1;
          default: ;
        endcase
      end
      OP_LDW: begin ctrl.regWrite = 1'b1; ctrl.aluSrcImm = 1'b1; ctrl.memToReg = 1'b1; end
      OP_STW: begin ctrl.aluSrcImm = 1'b1; ctrl.memWrite = 1'b1; end
      OP_BEQ: ctrl.brEq = 1'b1;
      OP_BNE: ctrl.brNe = 1'b1;
      OP_JMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NUM_REGS   = 32,
  localparam int IMEM_AW = $clog2(IMEM_WORDS),
  localparam int DMEM_AW = $clog2(DMEM_WORDS),
  localparam int LOAD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW,
  localparam int REG_AW  = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlT               ctrl,
  output logic [31:0]        instr,
  output logic [31:0]        pc,
  input  logic               loadEn,
  input  logic               loadToData,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [31:0]        loadData,
  input  logic [REG_AW-1:0]  dbgRegAddr,
  output logic [31:0]        dbgRegData,
  input  logic [DMEM_AW-1:0] dbgMemAddr,
  output logic [31:0]        dbgMemData
);
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] regs [NUM_REGS];

  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, wIdx;
  logic [31:0] rsVal, rtVal, imm, aluB, aluRes, wbData, pc4, pcNext, brTarget, jTarget;
  logic [DMEM_AW-1:0] memIdx;
  logic brTaken;

  assign instr = imem[pc[IMEM_AW+1:2]];
  assign rsIdx = instr[21 +: REG_AW];
  assign rtIdx = instr[16 +: REG_AW];
  assign rdIdx = instr[11 +: REG_AW];
  assign imm   = {{16{instr[15]}}, instr[15:0]};

  assign rsVal = (rsIdx == '0) ? 32'd0 : regs[rsIdx];
  assign rtVal = (rtIdx == '0) ? 32'd0 : regs[rtIdx];
  assign dbgRegData = (dbgRegAddr == '0) ? 32'd0 : regs[dbgRegAddr];
  assign dbgMemData = dmem[dbgMemAddr];

  assign aluB = ctrl.aluSrcImm ? imm : rtVal;
  always_comb begin
    unique case (ctrl.aluOp)
      ALU_SUB: aluRes = rsVal - aluB;
      ALU_SLT: aluRes = {31'd0, $signed(rsVal) < $signed(aluB)};
      default: aluRes = rsVal + aluB;
    endcase
  end

  assign memIdx = aluRes[DMEM_AW+1:2];
  assign wbData = ctrl.memToReg ? dmem[memIdx] : aluRes;
  assign wIdx   = ctrl.regDstRd ? rdIdx : rtIdx;

  assign pc4      = pc + 32'd4;
  assign brTarget = pc4 + {imm[29:0], 2'b00};
  assign jTarget  = {pc4[31:28], instr[25:0], 2'b00};
  assign brTaken  = (ctrl.brEq && (rsVal == rtVal)) || (ctrl.brNe && (rsVal != rtVal));

  always_comb begin
    if (ctrl.jumpReg)   pcNext = rsVal;
    else if (ctrl.jump) pcNext = jTarget;
    else if (brTaken)   pcNext = brTarget;
    else                pcNext = pc4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
      always_ff @(posedge clk) begin
        if (rst || g == 0) regs[g] <= '0;
        else if (ctrl.regWrite && wIdx == REG_AW'(g)) regs[g] <= wbData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (loadEn && !loadToData) imem[loadAddr[IMEM_AW-1:0]] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (loadEn && loadToData)           dmem[loadAddr[DMEM_AW-1:0]] <= loadData;
    else if (!rst && ctrl.memWrite)     dmem[memIdx] <= rtVal;
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IMEM_AW = $clog2(IMEM_WORDS),
  localparam int DMEM_AW = $clog2(DMEM_WORDS),
  localparam int LOAD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loadEn,
  input  logic               loadToData,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [31:0]        loadData,
  input  logic [4:0]         dbgRegAddr,
  output logic [31:0]        dbgRegData,
  input  logic [DMEM_AW-1:0] dbgMemAddr,
  output logic [31:0]        dbgMemData,
  output logic [31:0]        dbgPc
);
  ctrlT        ctrl;
  logic [31:0] instr;

  sc_control u_control (
    .opcode(instr[31:26]),
    .funct (instr[5:0]),
    .ctrl  (ctrl)
  );

  sc_datapath #(
    .IMEM_WORDS(IMEM_WORDS),
    .DMEM_WORDS(DMEM_WORDS),
    .NUM_REGS  (32)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .instr     (instr),
    .pc        (dbgPc),
    .loadEn    (loadEn),
    .loadToData(loadToData),
    .loadAddr  (loadAddr),
    .loadData  (loadData),
    .dbgRegAddr(dbgRegAddr),
    .dbgRegData(dbgRegData),
    .dbgMemAddr(dbgMemAddr),
    .dbgMemData(dbgMemData)
  );
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input ctrlT        ctrl,
  input logic [4:0]  dbgRegAddr,
  input logic [31:0] dbgRegData
);
  logic [5:0]  op, fn;
  logic [31:0] pcPlus4, jumpDest;
  logic        flowOp, knownOp;

  assign op       = instr[31:26];
  assign fn       = instr[5:0];
  assign pcPlus4  = pc + 32'd4;
  assign jumpDest = {pcPlus4[31:28], instr[25:0], 2'b00};
  assign flowOp   = (op == 6'd2) || (op == 6'd4) || (op == 6'd5) || (op == 6'd0 && fn == 6'd8);
  assign knownOp  = flowOp || op == 6'd35 || op == 6'd43 ||
                    (op == 6'd0 && (fn == 6'd32 || fn == 6'd34 || fn == 6'd42));

  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dbgRegAddr == 5'd0) |-> (dbgRegData == 32'd0)); // R2
  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    !flowOp |=> (pc == $past(pc) + 32'd4)); // R7
  AST_JUMP_DEST: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd2) |=> (pc == $past(jumpDest))); // R9
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !knownOp |-> (!ctrl.regWrite && !ctrl.memWrite && !ctrl.jump && !ctrl.jumpReg)); // R11
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (flowOp && op != 6'd0) |=> (pc[1:0] == 2'b00)); // R8
endmodule

bind sc_core sc_core_chk u_sc_core_chk (
  .clk       (clk),
  .rst       (rst),
  .pc        (dbgPc),
  .instr     (instr),
  .ctrl      (ctrl),
  .dbgRegAddr(dbgRegAddr),
  .dbgRegData(dbgRegData)
);

// File: tb/test_sc_core.sv
module test_sc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic        loadToData = 1'b0;
  logic [5:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [4:0]  dbgRegAddr = '0;
  logic [31:0] dbgRegData;
  logic [5:0]  dbgMemAddr = '0;
  logic [31:0] dbgMemData;
  logic [31:0] dbgPc;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sc_core i_sc_core (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadToData(loadToData),
    .loadAddr(loadAddr), .loadData(loadData), .dbgRegAddr(dbgRegAddr),
    .dbgRegData(dbgRegData), .dbgMemAddr(dbgMemAddr), .dbgMemData(dbgMemData),
    .dbgPc(dbgPc)
  );

  function automatic logic [31:0] rOp(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] iOp(int op, int rs, int rt, int off);
    return {op[5:0], rs[4:0], rt[4:0], off[15:0]};
  endfunction
  function automatic logic [31:0] jOp(int idx);
    return {6'd2, idx[25:0]};
  endfunction

  localparam int PROG_LEN = 27;
  localparam logic [31:0] PROG [PROG_LEN] = '{
    iOp(35, 0, 1, 0),      // 0  r1 = 5
    iOp(35, 0, 2, 4),      // 1  r2 = -3
    rOp(1, 2, 3, 32),      // 2  r3 = 2
    rOp(1, 2, 4, 34),      // 3  r4 = 8
    rOp(2, 1, 5, 42),      // 4  r5 = 1
    rOp(1, 2, 6, 42),      // 5  r6 = 0
    rOp(1, 1, 0, 32),      // 6  write to r0
    iOp(43, 0, 4, 12),     // 7  mem[3] = 8
    iOp(35, 0, 7, 12),     // 8  r7 = 8
    iOp(4, 4, 7, 1),       // 9  beq taken -> 11
    rOp(1, 1, 8, 32),      // 10 skipped
    iOp(5, 1, 1, 1),       // 11 bne not taken
    rOp(1, 1, 9, 32),      // 12 r9 = 10
    iOp(5, 1, 2, 1),       // 13 bne taken -> 15
    rOp(1, 1, 10, 32),     // 14 skipped
    iOp(35, 0, 11, 32),    // 15 r11 = table[8] = 80
    rOp(11, 0, 0, 8),      // 16 jr r11 -> 20
    rOp(1, 1, 12, 32),     // 17 skipped
    rOp(1, 1, 12, 32),     // 18 skipped
    rOp(1, 1, 12, 32),     // 19 landing check
    jOp(23),               // 20 j -> 23
    rOp(1, 1, 13, 32),     // 21 skipped
    rOp(1, 1, 13, 32),     // 22 skipped
    iOp(35, 11, 14, -4),   // 23 r14 = mem[19]
    32'hFC00_0000,         // 24 unused opcode 63
    rOp(3, 4, 16, 32),     // 25 r16 = 10
    iOp(4, 0, 0, -1)       // 26 spin in place
  };

  localparam int NUM_VEC = 15;
  localparam logic [36:0] VEC [NUM_VEC] = '{
    {5'd1,  32'd5},          // R5
    {5'd2,  32'hFFFF_FFFD},  // R5
    {5'd3,  32'd2},          // R3 add
    {5'd4,  32'd8},          // R3 sub
    {5'd5,  32'd1},          // R4 signed less
    {5'd6,  32'd0},          // R4 not less
    {5'd0,  32'd0},          // R2
    {5'd7,  32'd8},          // R6 store then load
    {5'd8,  32'd0},          // R8 beq taken skips
    {5'd9,  32'd10},         // R8 bne fall-through
    {5'd10, 32'd0},          // R8 bne taken skips
    {5'd12, 32'd0},          // R10 jr target
    {5'd13, 32'd0},          // R9 jump skips
    {5'd14, 32'h0000_1234},  // R5 negative offset
    {5'd16, 32'd10}          // R11 no-op leaves r3/r4 alone
  };
  localparam string VEC_REQ [NUM_VEC] = '{"R5","R5","R3","R3","R4","R4","R2",
    "R6","R8","R8","R8","R10","R9","R5","R11"};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic preload(logic toData, int idx, logic [31:0] val);
    @(negedge clk);
    loadEn = 1'b1; loadToData = toData; loadAddr = idx[5:0]; loadData = val;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic readReg(int idx, output logic [31:0] val);
    dbgRegAddr = idx[4:0];
    #0.5;
    val = dbgRegData;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk);
    check("R1 reset pc", dbgPc, 32'd0);
    readReg(9, v); check("R1 reset reg", v, 32'd0);

    for (int i = 0; i < PROG_LEN; i++) preload(1'b0, i, PROG[i]);
    preload(1'b1, 0, 32'd5);
    preload(1'b1, 1, 32'hFFFF_FFFD);
    preload(1'b1, 8, 32'd80);
    preload(1'b1, 19, 32'h0000_1234);
    dbgMemAddr = 6'd8; #0.5;
    check("R12 data preload", dbgMemData, 32'd80);

    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R7 pc step 1", dbgPc, 32'd4);
    readReg(1, v); check("R5 first load", v, 32'd5);
    @(negedge clk);
    check("R7 pc step 2", dbgPc, 32'd8);

    repeat (60) @(negedge clk);
    for (int k = 0; k < NUM_VEC; k++) begin
      readReg(int'(VEC[k][36:32]), v);
      check(VEC_REQ[k], v, VEC[k][31:0]);
    end
    check("R8 spin pc", dbgPc, 32'd104);
    dbgMemAddr = 6'd3; #0.5;
    check("R6 stored word", dbgMemData, 32'd8);
    dbgMemAddr = 6'd19; #0.5;
    check("R12 untouched word", dbgMemData, 32'h0000_1234);

    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 rereset pc", dbgPc, 32'd0);
    readReg(4, v); check("R1 rereset reg", v, 32'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule